// File: doc/BRIEF.md
# Load-Use Interlock Unit

This block decides, every cycle, whether the instruction sitting in the register-read (decode) stage must wait because one of its source registers is the destination of a load that is still travelling through the pipe. Load data can be forwarded only once the load reaches write-back. A dependent instruction therefore cannot proceed while the load is in the ALU stage, and it still cannot proceed while the load is in the memory stage. The unit looks at both of those stages, so a back-to-back load and use costs two bubble cycles, and a use that follows one unrelated instruction costs one.

The logic is purely combinational. When a hazard is seen, it raises a hold for the program counter and a hold for the fetch/decode pipeline register, so the dependent instruction stays where it is. It also raises a bubble control that makes the ALU-stage instruction register load a NOP in place of the held instruction. The register-file write enable and the memory write enable that go into the ALU-stage register come out of this block. They pass through unchanged when no hazard is seen and are forced low for a bubble. Forwarding selection and memory timing belong to other blocks.

Top module: `load_use_interlock`

## Requirements
- R1: When a source that the decoding instruction reads (its read flag is 1) equals the nonzero destination of a load in the ALU stage whose register-write flag is 1, `hold_pc`, `hold_fd` and `bubble_ex` are all 1.
- R2: The same stall occurs when the matching load, with its register-write flag at 1 and a nonzero destination, is in the memory stage.
- R3: A source register number of 0 never causes a stall, whatever the producer stages hold.
- R4: A source whose read flag is 0 never causes a stall.
- R5: A producer that is not a load, a load whose register-write flag is 0, and a load whose destination is register 0 never cause a stall.
- R6: `hold_pc`, `hold_fd` and `bubble_ex` are always equal, and all three are 0 when none of R1 and R2 applies.
- R7: When `bubble_ex` is 1, `bub_rf_we` and `bub_mem_we` are 0. When it is 0, they equal `dec_rf_we` and `dec_mem_we`.
- R8: A dependent instruction that follows its load directly stalls for exactly two cycles, while the load is in the ALU stage and then in the memory stage. It is released in the cycle the load is in write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src | input | NUM_SRC x REG_W | Source register numbers of the decoding instruction |
| dec_rd_en | input | NUM_SRC | Per-source flag: the instruction really reads this source |
| dec_rf_we | input | 1 | Register-file write enable of the decoding instruction |
| dec_mem_we | input | 1 | Memory write enable of the decoding instruction |
| ex_dst | input | REG_W | Destination register of the ALU-stage instruction |
| ex_rf_we | input | 1 | ALU-stage instruction writes the register file |
| ex_is_load | input | 1 | ALU-stage instruction is a load |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_rf_we | input | 1 | Memory-stage instruction writes the register file |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_fd | output | 1 | Keep the fetch/decode pipeline register unchanged |
| bubble_ex | output | 1 | Load a NOP into the ALU-stage instruction register |
| bub_rf_we | output | 1 | Register-file write enable to load into the ALU stage |
| bub_mem_we | output | 1 | Memory write enable to load into the ALU stage |

## Verification
The bench builds the block with its defaults: two sources and 5-bit register numbers. Random register numbers are drawn from the low range 0 to 3, so register 0 and matches between sources and destinations both turn up often. This exercises single-stage hits, double hits in both stages, and the zero-register cases against an independent reference function. Directed cases then walk one load through the ALU, memory and write-back stages with the dependent instruction held in decode, to confirm the two-cycle stall and its release.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // Producer stages that can hold an unfinished load, youngest first.
  typedef enum logic [0:0] {
    STG_EX  = 1'b0,
    STG_MEM = 1'b1
  } ilk_stage_e;

  localparam int unsigned NUM_STG = 2;
endpackage

// File: rtl/ilk_producer.sv
module ilk_producer #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dst,
  input  logic             rf_we,
  input  logic             is_load,
  output logic             pend_vld,
  output logic [REG_W-1:0] pend_dst
);
  // A producer is pending only when it is a load that really writes a
  // nonzero register (R5).
  always_comb begin
    pend_vld = is_load && rf_we && (dst != '0);
    pend_dst = dst;
  end
endmodule

// File: rtl/ilk_src_match.sv
module ilk_src_match #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NSTG  = 2
) (
  input  logic [REG_W-1:0]           src,
  input  logic                       rd_en,
  input  logic [NSTG-1:0]            pend_vld,
  input  logic [NSTG-1:0][REG_W-1:0] pend_dst,
  output logic                       hit
);
  logic [NSTG-1:0] stg_hit;
  logic            src_live;

  // Register 0 and unread sources are never live (R3, R4).
  always_comb src_live = rd_en && (src != '0);

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    always_comb stg_hit[s] = src_live && pend_vld[s] && (pend_dst[s] == src);
  end

  always_comb hit = |stg_hit;
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned REG_W   = 5
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src,
  input  logic [NUM_SRC-1:0]            dec_rd_en,
  input  logic                          dec_rf_we,
  input  logic                          dec_mem_we,
  input  logic [REG_W-1:0]              ex_dst,
  input  logic                          ex_rf_we,
  input  logic                          ex_is_load,
  input  logic [REG_W-1:0]              mem_dst,
  input  logic                          mem_rf_we,
  input  logic                          mem_is_load,
  output logic                          hold_pc,
  output logic                          hold_fd,
  output logic                          bubble_ex,
  output logic                          bub_rf_we,
  output logic                          bub_mem_we
);
  import ilk_pkg::*;

  localparam int unsigned NSTG = NUM_STG;

  logic [NSTG-1:0][REG_W-1:0] raw_dst;
  logic [NSTG-1:0]            raw_we;
  logic [NSTG-1:0]            raw_ld;
  logic [NSTG-1:0]            pend_vld;
  logic [NSTG-1:0][REG_W-1:0] pend_dst;
  logic [NUM_SRC-1:0]         src_hit;
  logic                       stall;

  // Gather the producer stages into indexed form.
  always_comb begin
    raw_dst[STG_EX]  = ex_dst;
    raw_we[STG_EX]   = ex_rf_we;
    raw_ld[STG_EX]   = ex_is_load;
    raw_dst[STG_MEM] = mem_dst;
    raw_we[STG_MEM]  = mem_rf_we;
    raw_ld[STG_MEM]  = mem_is_load;
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_prod
    ilk_producer #(.REG_W(REG_W)) u_prod (
      .dst      (raw_dst[s]),
      .rf_we    (raw_we[s]),
      .is_load  (raw_ld[s]),
      .pend_vld (pend_vld[s]),
      .pend_dst (pend_dst[s])
    );
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    ilk_src_match #(.REG_W(REG_W), .NSTG(NSTG)) u_match (
      .src      (dec_src[i]),
      .rd_en    (dec_rd_en[i]),
      .pend_vld (pend_vld),
      .pend_dst (pend_dst),
      .hit      (src_hit[i])
    );
  end

  always_comb stall = |src_hit;

  // One stall decision drives every hold and the bubble (R6).
  always_comb begin
    hold_pc    = stall;
    hold_fd    = stall;
    bubble_ex  = stall;
    bub_rf_we  = dec_rf_we  && !stall;
    bub_mem_we = dec_mem_we && !stall;
  end

  // Port-level checks, derived from raw ports rather than internal nets.
  logic chk_ex_hit;
  logic chk_mem_hit;
  logic chk_any_live;

  always_comb begin
    chk_ex_hit   = 1'b0;
    chk_mem_hit  = 1'b0;
    chk_any_live = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (dec_rd_en[i] && dec_src[i] != '0) begin
        chk_any_live = 1'b1;
        if (ex_is_load && ex_rf_we && ex_dst == dec_src[i])    chk_ex_hit  = 1'b1;
        if (mem_is_load && mem_rf_we && mem_dst == dec_src[i]) chk_mem_hit = 1'b1;
      end
    end
  end

  always_comb begin
    assert_ex_load_stall_R1 : assert (!chk_ex_hit || (hold_pc && hold_fd && bubble_ex));
    assert_mem_load_stall_R2 : assert (!chk_mem_hit || (hold_pc && hold_fd && bubble_ex));
    // R3/R4: without any live source there is nothing to wait for
    assert_no_live_src_R3 : assert (chk_any_live || !bubble_ex);
    assert_unread_src_R4 : assert (dec_rd_en != '0 || !hold_pc);
    assert_no_pending_load_R5 : assert ((ex_is_load && ex_rf_we) || (mem_is_load && mem_rf_we) || !hold_fd);
    assert_holds_agree_R6 : assert ((hold_pc == bubble_ex) && (hold_fd == bubble_ex));
    assert_only_on_hit_R6 : assert (chk_ex_hit || chk_mem_hit || !bubble_ex);
    assert_bubble_enables_R7 : assert (bubble_ex ? (!bub_rf_we && !bub_mem_we)
                                                 : (bub_rf_we == dec_rf_we && bub_mem_we == dec_mem_we));
  end
endmodule

// File: tb/tb_load_use_interlock.sv
module tb_load_use_interlock;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_RAND = 800;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NUM_SRC-1:0][REG_W-1:0] dec_src;
  logic [NUM_SRC-1:0]            dec_rd_en;
  logic dec_rf_we, dec_mem_we;
  logic [REG_W-1:0] ex_dst, mem_dst;
  logic ex_rf_we, ex_is_load, mem_rf_we, mem_is_load;
  logic hold_pc, hold_fd, bubble_ex, bub_rf_we, bub_mem_we;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  load_use_interlock #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) dut (
    .dec_src(dec_src), .dec_rd_en(dec_rd_en),
    .dec_rf_we(dec_rf_we), .dec_mem_we(dec_mem_we),
    .ex_dst(ex_dst), .ex_rf_we(ex_rf_we), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_rf_we(mem_rf_we), .mem_is_load(mem_is_load),
    .hold_pc(hold_pc), .hold_fd(hold_fd), .bubble_ex(bubble_ex),
    .bub_rf_we(bub_rf_we), .bub_mem_we(bub_mem_we)
  );

  // Reference: does one producer stage block one source?
  function automatic bit blocks(input logic [REG_W-1:0] s, input bit rd,
                                input logic [REG_W-1:0] d, input bit we, input bit ld);
    return rd && (s != 0) && ld && we && (d == s);
  endfunction

  function automatic logic [4:0] expect_out();
    bit st = 0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (blocks(dec_src[i], dec_rd_en[i], ex_dst, ex_rf_we, ex_is_load))    st = 1;
      if (blocks(dec_src[i], dec_rd_en[i], mem_dst, mem_rf_we, mem_is_load)) st = 1;
    end
    return {st, st, st, dec_rf_we & ~st, dec_mem_we & ~st};
  endfunction

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {hold_pc, hold_fd, bubble_ex, bub_rf_we, bub_mem_we};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {pc,fd,bub,rfwe,memwe} act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic set_dec(input int s0, input bit r0, input int s1, input bit r1,
                         input bit rfwe, input bit mwe);
    dec_src[0] = REG_W'(s0); dec_rd_en[0] = r0;
    dec_src[1] = REG_W'(s1); dec_rd_en[1] = r1;
    dec_rf_we = rfwe; dec_mem_we = mwe;
  endtask

  task automatic set_ex(input int d, input bit we, input bit ld);
    ex_dst = REG_W'(d); ex_rf_we = we; ex_is_load = ld;
  endtask

  task automatic set_mem(input int d, input bit we, input bit ld);
    mem_dst = REG_W'(d); mem_rf_we = we; mem_is_load = ld;
  endtask

  task automatic step_check(input string tag, input logic [4:0] exp);
    @(negedge clk);
    check(tag, exp);
    @(posedge clk);
  endtask

  initial begin
    set_dec(0, 0, 0, 0, 0, 0);
    set_ex(0, 0, 0);
    set_mem(0, 0, 0);
    @(posedge clk);

    // Idle state: no producers, nothing read
    step_check("R6 idle", 5'b00000);

    // R1: load to r7 in ALU stage, source 0 reads r7
    set_dec(7, 1, 3, 1, 1, 1); set_ex(7, 1, 1); set_mem(0, 0, 0);
    step_check("R1 ex load match src0", 5'b11100);
    // R1 via source 1
    set_dec(2, 1, 7, 1, 1, 0); set_ex(7, 1, 1);
    step_check("R1 ex load match src1", 5'b11100);
    // R2: load in memory stage
    set_dec(9, 1, 0, 0, 0, 1); set_ex(0, 0, 0); set_mem(9, 1, 1);
    step_check("R2 mem load match", 5'b11100);
    // R3: source 0 with load to r0 in both stages
    set_dec(0, 1, 0, 1, 1, 1); set_ex(0, 1, 1); set_mem(0, 1, 1);
    step_check("R3 zero source", 5'b00011);
    // R4: matching source not read
    set_dec(7, 0, 4, 1, 1, 0); set_ex(7, 1, 1); set_mem(7, 1, 1);
    step_check("R4 unread source", 5'b00010);
    // R5: ALU op (not a load) writing r7
    set_dec(7, 1, 0, 0, 1, 1); set_ex(7, 1, 0); set_mem(7, 1, 0);
    step_check("R5 non-load producer", 5'b00011);
    // R5: load with write flag cleared
    set_ex(7, 0, 1); set_mem(7, 0, 1);
    step_check("R5 load without write", 5'b00011);
    // R5: load to r0, source r0 read: still no stall
    set_dec(0, 1, 5, 1, 0, 1); set_ex(0, 1, 1); set_mem(0, 1, 1);
    step_check("R5 load to r0", 5'b00001);
    // R7: bubble clears both enables
    set_dec(11, 1, 11, 1, 1, 1); set_ex(11, 1, 1); set_mem(0, 0, 0);
    step_check("R7 bubble clears enables", 5'b11100);

    // R8: load r6 then dependent use; walk the load through the pipe
    set_dec(6, 1, 1, 1, 1, 0);
    set_ex(6, 1, 1); set_mem(0, 0, 0);
    step_check("R8 stall cycle 1 (load in ALU)", 5'b11100);
    set_ex(0, 0, 0); set_mem(6, 1, 1);   // bubble in ALU, load in memory
    step_check("R8 stall cycle 2 (load in MEM)", 5'b11100);
    set_ex(0, 0, 0); set_mem(0, 0, 0);   // load in write-back
    step_check("R8 release (load in WB)", 5'b00010);
    // R8: one independent instruction between: single stall
    set_ex(3, 1, 0); set_mem(6, 1, 1);
    step_check("R8 single stall after gap", 5'b11100);

    // Random mix with small register numbers
    void'($urandom(32'd20240611));
    for (int k = 0; k < N_RAND; k++) begin
      set_dec($urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
              1'($urandom), 1'($urandom));
      set_ex($urandom_range(0, 3), 1'($urandom), 1'($urandom));
      set_mem($urandom_range(0, 3), 1'($urandom), 1'($urandom));
      @(negedge clk);
      check("R1/R2/R6 random", expect_out());
      @(posedge clk);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule